// File: doc/BRIEF.md
# Motion History Image Updater

This block is a streaming per-pixel engine that keeps a decaying motion timestamp for each pixel of a greyscale image. For each pixel it takes three values: the current frame sample, the previous frame sample and the stored history value. It then emits a new history value. When the absolute difference between the two frame samples is above a programmable threshold, the pixel counts as moving and its history jumps to the maximum value. When the pixel is not moving, the history drops by one per frame and stops at zero. A one-bit energy output marks every pixel whose new history is non-zero.

A run covers one segment of the raster-ordered image, given by an inclusive first and last pixel index. Software or a sequencer pulses `start`, streams in the pixels of that segment, and collects the results on a valid/ready output stream. The output carries the pixel index so that it can be written back to history memory. Each instance owns a disjoint segment, so several copies can share one image without one copy reading a history pixel that another copy is rewriting. `done` pulses once the last result of the segment has been handed over.

Top module: `mhi_updater`

## Requirements
- R1: After reset, `upd_valid`, `pix_ready` and `done` are all 0.
- R2: A pixel is moving when the absolute difference between `pix_cur` and `pix_prev` is strictly greater than `cfg_thresh`, and the difference counts in either sign. A moving pixel produces `upd_hist` = 255 whatever its old history was.
- R3: A difference exactly equal to `cfg_thresh` does not count as motion, and the pixel decays instead. With `cfg_thresh` = 255 no pixel can move.
- R4: A pixel that is not moving produces `upd_hist` = old history minus 1. An old history of 0 stays 0.
- R5: `upd_energy` is 1 exactly when `upd_hist` is non-zero.
- R6: After a `start`, `pix_ready` accepts exactly last minus first plus 1 pixels and then stays low until the next `start`.
- R7: Results leave in input order. `upd_idx` runs from `cfg_seg_first` up to `cfg_seg_last` in steps of one, using the values sampled at `start`.
- R8: While `upd_ready` stays high, a pixel accepted on clock edge E appears on the output during the cycle after edge E+1. This is a latency of two cycles.
- R9: While `upd_valid` is 1 and `upd_ready` is 0, the next cycle keeps `upd_valid` high with `upd_hist` and `upd_idx` unchanged.
- R10: `done` is a single-cycle pulse in the cycle right after the handshake of the result whose index is `cfg_seg_last`.
- R11: A `start` that arrives while a segment is still in flight is ignored, and so is any change it carries to the segment bounds. A `start` given in the same cycle as `done` is accepted and begins the next segment.
- R12: A segment with first equal to last processes exactly one pixel. Segments may end on the final index of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_thresh | input | 8 | Motion threshold; a difference must exceed it |
| cfg_seg_first | input | 15 | First pixel index of the segment, sampled at start |
| cfg_seg_last | input | 15 | Last pixel index of the segment, sampled at start |
| start | input | 1 | Begins a segment when the block is idle |
| done | output | 1 | One-cycle pulse after the final result is taken |
| pix_valid | input | 1 | Input pixel triple is valid |
| pix_ready | output | 1 | Block accepts an input pixel triple |
| pix_cur | input | 8 | Current frame sample |
| pix_prev | input | 8 | Previous frame sample |
| pix_hist | input | 8 | Stored history value of the pixel |
| upd_valid | output | 1 | Updated result is valid |
| upd_ready | input | 1 | Downstream accepts the result |
| upd_hist | output | 8 | New history value |
| upd_energy | output | 1 | New history is non-zero |
| upd_idx | output | 15 | Pixel index of the result |

## Verification
Completion of one segment and the launch of the next can fall in the same cycle: `done` rises in exactly the cycle where a fresh `start` is allowed. The bench provokes this by raising `start` with new bounds in the cycle it sees `done`. It then judges the second segment through its index sequence, its values and its own `done` pulse. A second overlap is output backpressure against new input. Irregular `upd_ready` gaps and input bubbles run at the same time, and every stalled cycle is checked for a frozen result and every handshake for the expected index and value.

// File: rtl/mhi_pkg.sv
package mhi_pkg;

   // Variant selector for the motion comparator.
   typedef enum logic [0:0] {
      DIFF_ABS   = 1'b0,   // form |a-b| then compare with threshold
      DIFF_SPLIT = 1'b1    // two widened one-sided compares, no subtract
   } diff_style_e;

endpackage

// File: rtl/mhi_motion_detect.sv
module mhi_motion_detect
   import mhi_pkg::*;
#(
   parameter int          PIX_W      = 8,
   parameter diff_style_e DIFF_STYLE = DIFF_ABS
) (
   input  logic [PIX_W-1:0] cur,
   input  logic [PIX_W-1:0] prev,
   input  logic [PIX_W-1:0] thresh,
   output logic             moving
);

   localparam int WIDE_W = PIX_W + 1;

   generate
      if (DIFF_STYLE == DIFF_ABS) begin : g_abs
         logic [PIX_W-1:0] mag;
         always_comb begin
            mag    = (cur >= prev) ? (cur - prev) : (prev - cur);
            moving = (mag > thresh);
         end
      end else begin : g_split
         logic [WIDE_W-1:0] cur_w, prev_w, thr_w;
         always_comb begin
            cur_w  = {1'b0, cur};
            prev_w = {1'b0, prev};
            thr_w  = {1'b0, thresh};
            moving = (cur_w > prev_w + thr_w) || (prev_w > cur_w + thr_w);
         end
      end
   endgenerate

endmodule

// File: rtl/mhi_hist_pipe.sv
module mhi_hist_pipe #(
   parameter int PIX_W    = 8,
   parameter int IDX_W    = 15,
   parameter int HIST_MAX = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             in_moving,
   input  logic [PIX_W-1:0] in_hist,
   input  logic [IDX_W-1:0] in_idx,
   input  logic             in_last,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [PIX_W-1:0] out_hist,
   output logic             out_energy,
   output logic [IDX_W-1:0] out_idx,
   output logic             out_last
);

   localparam logic [PIX_W-1:0] TOP_VAL = PIX_W'(HIST_MAX);
   localparam logic [PIX_W-1:0] ONE_VAL = PIX_W'(1);

   // stage A: moving flag registered with the old history
   logic             a_vld_q, a_mov_q, a_last_q;
   logic [PIX_W-1:0] a_hist_q;
   logic [IDX_W-1:0] a_idx_q;
   // stage B: updated history
   logic             b_vld_q, b_nrg_q, b_last_q;
   logic [PIX_W-1:0] b_hist_q;
   logic [IDX_W-1:0] b_idx_q;

   logic b_take, a_take, a_moves;

   assign b_take   = !b_vld_q || out_ready;
   assign a_take   = !a_vld_q || b_take;
   assign a_moves  = a_vld_q && b_take;
   assign in_ready = a_take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_vld_q  <= 1'b0;
         a_mov_q  <= 1'b0;
         a_last_q <= 1'b0;
         a_hist_q <= '0;
         a_idx_q  <= '0;
      end else if (a_take) begin
         a_vld_q <= in_valid;
         if (in_valid) begin
            a_mov_q  <= in_moving;
            a_hist_q <= in_hist;
            a_idx_q  <= in_idx;
            a_last_q <= in_last;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_vld_q  <= 1'b0;
         b_nrg_q  <= 1'b0;
         b_last_q <= 1'b0;
         b_hist_q <= '0;
         b_idx_q  <= '0;
      end else if (b_take) begin
         b_vld_q <= a_vld_q;
         if (a_vld_q) begin
            if (a_mov_q)
               b_hist_q <= TOP_VAL;
            else if (a_hist_q == '0)
               b_hist_q <= '0;
            else
               b_hist_q <= a_hist_q - ONE_VAL;
            // energy derived separately: set on motion or when old > 1
            b_nrg_q  <= a_mov_q || (a_hist_q > ONE_VAL);
            b_idx_q  <= a_idx_q;
            b_last_q <= a_last_q;
         end
      end
   end

   assign out_valid  = b_vld_q;
   assign out_hist   = b_hist_q;
   assign out_energy = b_nrg_q;
   assign out_idx    = b_idx_q;
   assign out_last   = b_last_q;

   // R2: a moving pixel lands at the top value
   a_r2_top_on_motion: assert property (@(posedge clk) disable iff (!rst_n)
      (a_moves && a_mov_q) |=> (b_hist_q == TOP_VAL));

   // R4: a still pixel with zero history stays at zero
   a_r4_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (a_moves && !a_mov_q && a_hist_q == '0) |=> (b_hist_q == '0));

   // R9: a stalled result holds
   a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_hist) && $stable(out_idx)));

endmodule

// File: rtl/mhi_seg_ctrl.sv
module mhi_seg_ctrl #(
   parameter int IDX_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] cfg_first,
   input  logic [IDX_W-1:0] cfg_last,
   input  logic             in_fire,
   input  logic             out_fire,
   input  logic             out_last,
   output logic             feed_en,
   output logic [IDX_W-1:0] cur_idx,
   output logic             cur_last,
   output logic             done
);

   localparam logic [IDX_W-1:0] STEP = IDX_W'(1);

   logic             busy_q, feed_q, done_q;
   logic [IDX_W-1:0] next_q, stop_q;

   assign feed_en  = feed_q;
   assign cur_idx  = next_q;
   assign cur_last = (next_q == stop_q);
   assign done     = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         feed_q <= 1'b0;
         done_q <= 1'b0;
         next_q <= '0;
         stop_q <= '0;
      end else begin
         done_q <= out_fire && out_last;
         if (start && !busy_q) begin
            busy_q <= 1'b1;
            feed_q <= 1'b1;
            next_q <= cfg_first;
            stop_q <= cfg_last;
         end else begin
            if (in_fire) begin
               next_q <= next_q + STEP;
               if (cur_last)
                  feed_q <= 1'b0;
            end
            if (out_fire && out_last)
               busy_q <= 1'b0;
         end
      end
   end

   // R10: done never lasts two cycles and comes only once idle
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy_q);

   // R11: a start during a run leaves the bound untouched
   a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy_q) |=> $stable(stop_q));

   // R6: input stops right after the last index is taken
   a_r6_feed_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fire && cur_last) |=> !feed_q);

endmodule

// File: rtl/mhi_updater.sv
module mhi_updater
   import mhi_pkg::*;
#(
   parameter int          FRAME_W    = 200,
   parameter int          FRAME_H    = 160,
   parameter int          PIX_W      = 8,
   parameter int          HIST_MAX   = 255,
   parameter diff_style_e DIFF_STYLE = DIFF_ABS,
   localparam int         NPIX       = FRAME_W * FRAME_H,
   localparam int         IDX_W      = $clog2(NPIX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] cfg_thresh,
   input  logic [IDX_W-1:0] cfg_seg_first,
   input  logic [IDX_W-1:0] cfg_seg_last,
   input  logic             start,
   output logic             done,
   input  logic             pix_valid,
   output logic             pix_ready,
   input  logic [PIX_W-1:0] pix_cur,
   input  logic [PIX_W-1:0] pix_prev,
   input  logic [PIX_W-1:0] pix_hist,
   output logic             upd_valid,
   input  logic             upd_ready,
   output logic [PIX_W-1:0] upd_hist,
   output logic             upd_energy,
   output logic [IDX_W-1:0] upd_idx
);

   // elaboration-time parameter checks
   generate
      if (!((FRAME_W == 200 && FRAME_H == 160) || (FRAME_W == 100 && FRAME_H == 80))) begin : g_bad_frame
         $error("mhi_updater: frame must be 200x160 or 100x80");
      end
      if (PIX_W != 8) begin : g_bad_pix
         $error("mhi_updater: pixels are 8-bit greyscale");
      end
      if (HIST_MAX < 1 || HIST_MAX >= (1 << PIX_W)) begin : g_bad_max
         $error("mhi_updater: HIST_MAX must fit the history width and be non-zero");
      end
   endgenerate

   logic             feed_en, cur_last, moving, pipe_rdy, pipe_vld_in;
   logic             in_fire, out_fire, out_last;
   logic [IDX_W-1:0] cur_idx;

   assign pipe_vld_in = pix_valid && feed_en;
   assign pix_ready   = feed_en && pipe_rdy;
   assign in_fire     = pix_valid && pix_ready;
   assign out_fire    = upd_valid && upd_ready;

   mhi_seg_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cfg_first(cfg_seg_first),
      .cfg_last (cfg_seg_last),
      .in_fire  (in_fire),
      .out_fire (out_fire),
      .out_last (out_last),
      .feed_en  (feed_en),
      .cur_idx  (cur_idx),
      .cur_last (cur_last),
      .done     (done)
   );

   mhi_motion_detect #(.PIX_W(PIX_W), .DIFF_STYLE(DIFF_STYLE)) u_detect (
      .cur   (pix_cur),
      .prev  (pix_prev),
      .thresh(cfg_thresh),
      .moving(moving)
   );

   mhi_hist_pipe #(.PIX_W(PIX_W), .IDX_W(IDX_W), .HIST_MAX(HIST_MAX)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (pipe_vld_in),
      .in_ready  (pipe_rdy),
      .in_moving (moving),
      .in_hist   (pix_hist),
      .in_idx    (cur_idx),
      .in_last   (cur_last),
      .out_valid (upd_valid),
      .out_ready (upd_ready),
      .out_hist  (upd_hist),
      .out_energy(upd_energy),
      .out_idx   (upd_idx),
      .out_last  (out_last)
   );

   // R5: energy flag agrees with the emitted history
   a_r5_energy_match: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> (upd_energy == (upd_hist != '0)));

   // R6: no input is taken outside a segment
   a_r6_idle_no_take: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !pix_ready);

endmodule

// File: tb/mhi_updater_tb.sv
module mhi_updater_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_thresh = '0;
   logic [14:0] cfg_seg_first = '0;
   logic [14:0] cfg_seg_last = '0;
   logic        start = 1'b0;
   logic        done;
   logic        pix_valid = 1'b0;
   logic        pix_ready;
   logic [7:0]  pix_cur = '0, pix_prev = '0, pix_hist = '0;
   logic        upd_valid;
   logic        upd_ready = 1'b1;
   logic [7:0]  upd_hist;
   logic        upd_energy;
   logic [14:0] upd_idx;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   mhi_updater u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh),
      .cfg_seg_first(cfg_seg_first), .cfg_seg_last(cfg_seg_last),
      .start(start), .done(done),
      .pix_valid(pix_valid), .pix_ready(pix_ready),
      .pix_cur(pix_cur), .pix_prev(pix_prev), .pix_hist(pix_hist),
      .upd_valid(upd_valid), .upd_ready(upd_ready),
      .upd_hist(upd_hist), .upd_energy(upd_energy), .upd_idx(upd_idx)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int lim(input int v);
      return (v > 255) ? 255 : v;
   endfunction

   // stimulus per pixel index, with corner cases on fixed slots
   task automatic pat(input int i, input int thr, output int c, output int p, output int h);
      case (i % 8)
         0: begin c = 50;               p = lim(50 + thr + 1); h = (i * 7) % 256; end
         1: begin c = lim(40 + thr);    p = 40;                h = 0;             end
         2: begin c = 77;               p = 77;                h = 1;             end
         3: begin c = lim(10 + thr + 1); p = 10;               h = 0;             end
         4: begin c = (i * 37 + 13) % 256; p = (i * 91 + 5) % 256; h = (i * 53) % 256; end
         5: begin c = 200;              p = 200;               h = 255;           end
         6: begin c = (i * 17) % 256;   p = (i * 29 + 100) % 256; h = (i * 3) % 256; end
         default: begin c = 0;          p = 255;               h = 9;             end
      endcase
   endtask

   // expected history from the requirements
   task automatic expect_hist(input int c, input int p, input int h, input int thr,
                              output int e, output string tag);
      int d;
      d = (c > p) ? c - p : p - c;
      if (d > thr) begin e = 255; tag = "R2"; end
      else begin
         e = (h == 0) ? 0 : h - 1;
         tag = (d == thr) ? "R3" : "R4";
      end
   endtask

   task automatic run_seg(input int first, input int last, input int thr,
                          input bit stall, input bit mid_start, input bit skip_start,
                          input bit chain, input int nfirst, input int nlast);
      int acc[64];
      int k, oexp, t, last_out_t, hold_h, hold_i, c, p, h, e;
      bit seen_done, hold_v;
      string tag;
      k = first; oexp = first; t = 0; last_out_t = -10;
      seen_done = 0; hold_v = 0; hold_h = 0; hold_i = 0;
      cfg_thresh = 8'(thr);
      if (!skip_start) begin
         @(negedge clk);
         cfg_seg_first = 15'(first);
         cfg_seg_last  = 15'(last);
         start = 1'b1;
         @(negedge clk);
      end
      start = 1'b0;
      while (!seen_done && t < 3000) begin
         start = 1'b0;
         if (mid_start && t == 3) begin
            start = 1'b1;                    // R11: must be ignored
            cfg_seg_first = 15'(first + 5);
            cfg_seg_last  = 15'(first + 6);
         end
         upd_ready = stall ? !((t % 3) == 1 || (t % 7) == 0) : 1'b1;
         if (k <= last && !(stall && (t % 5) == 2)) begin
            pat(k, thr, c, p, h);
            pix_valid = 1'b1;
            pix_cur = 8'(c); pix_prev = 8'(p); pix_hist = 8'(h);
         end else pix_valid = 1'b0;
         #1;
         if (pix_valid && pix_ready) begin
            acc[k - first] = t;
            k++;
         end
         if (hold_v)
            chk(upd_valid && int'(upd_hist) == hold_h && int'(upd_idx) == hold_i,
                "R9 stalled result", int'(upd_hist), hold_h);
         hold_v = 0;
         if (upd_valid && upd_ready) begin
            chk(int'(upd_idx) == oexp, "R7 order", int'(upd_idx), oexp);
            pat(oexp, thr, c, p, h);
            expect_hist(c, p, h, thr, e, tag);
            chk(int'(upd_hist) == e, tag, int'(upd_hist), e);
            chk(upd_energy == (e != 0), "R5 energy", int'(upd_energy), int'(e != 0));
            if (!stall)
               chk(t - acc[oexp - first] == 2, "R8 latency", t - acc[oexp - first], 2);
            if (oexp == last) last_out_t = t;
            oexp++;
         end else if (upd_valid) begin
            hold_v = 1; hold_h = int'(upd_hist); hold_i = int'(upd_idx);
         end
         if (done) begin
            chk(t == last_out_t + 1, "R10 done timing", t, last_out_t + 1);
            seen_done = 1;
            pix_valid = 1'b0;
            if (chain) begin
               start = 1'b1;                  // R11: start in the done cycle
               cfg_seg_first = 15'(nfirst);
               cfg_seg_last  = 15'(nlast);
            end
         end
         @(negedge clk);
         t++;
      end
      chk(seen_done, "R10 done seen", int'(seen_done), 1);
      chk(oexp == last + 1, "R6 result count", oexp - first, last - first + 1);
      chk(k == last + 1, "R6 accept count", k - first, last - first + 1);
      if (!chain) begin
         #1;
         chk(!done, "R10 single pulse", int'(done), 0);
         chk(!pix_ready, "R6 ready low after segment", int'(pix_ready), 0);
      end
   endtask

   task automatic test_reset();
      #1;
      chk(!upd_valid, "R1 upd_valid", int'(upd_valid), 0);
      chk(!pix_ready, "R1 pix_ready", int'(pix_ready), 0);
      chk(!done, "R1 done", int'(done), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!pix_ready, "R6 idle ready", int'(pix_ready), 0);
   endtask

   task automatic test_basic();          // R2 R3 R4 R5 R7 R8
      run_seg(0, 23, 20, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
   endtask

   task automatic test_backpressure();   // R9
      run_seg(100, 150, 60, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
   endtask

   task automatic test_single_last();    // R12
      run_seg(31999, 31999, 30, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
   endtask

   task automatic test_thresholds();     // R3 with thr=0 and thr=255, R11 ignore
      run_seg(200, 215, 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
      run_seg(300, 315, 255, 1'b0, 1'b1, 1'b0, 1'b0, 0, 0);
   endtask

   task automatic test_chain();          // R11 start in done cycle
      run_seg(500, 509, 15, 1'b0, 1'b0, 1'b0, 1'b1, 600, 607);
      run_seg(600, 607, 15, 1'b1, 1'b0, 1'b1, 1'b0, 0, 0);
   endtask

   initial begin
      test_reset();
      test_basic();
      test_backpressure();
      test_single_last();
      test_thresholds();
      test_chain();
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule